// File: doc/BRIEF.md
# Tolerant Configuration Address Port

This block is the host-side front end for indirect configuration-space accesses. Software writes a target address into an address register and then reads or writes a data window; each data-window access becomes one configuration read or write request on a downstream request/response interface. Software is known to write sloppy values into the address register (enable bit missing, low bits set), so the block cleans up every accepted value: it always clears the two low bits and always forces the enable bit (bit 31) on.

The block splits the stored address into bus, device, function and dword-register fields for the downstream request. It derives byte lanes from the low bits of the data-window offset, using little-endian lane order. A read through the window stalls the access interface until the downstream response arrives. The block also holds a 32-bit scratch/status register. It merges the four interrupt pins of every slot into a single interrupt output.

The access interface is a simple valid/ready request with a one-cycle done pulse. `acc_size` encodes 1, 2 or 4 bytes as 0, 1 or 2. Offsets are decoded as follows: 0 is the address register, 4 to 7 is the data window, and 0xE0 is the status register.

Top module: `cfg_addr_port`

## Requirements
- R1: After reset the stored address and the status register read as zero, `irq_out` is low and no downstream request is issued.
- R2: A write to offset 0 changes the stored address only when `acc_size` is 2 (4 bytes); writes at offsets 1 to 3, or at offset 0 with size 0 or 1, leave it unchanged.
- R3: An accepted address write stores the written value with bits 1:0 cleared and bit 31 set; a read at offset 0 returns the stored value.
- R4: An access at offsets 4 to 7 while stored bit 31 is set issues exactly one one-cycle request whose bus, device, function and register fields are stored bits 23:16, 15:11, 10:8 and 7:2.
- R5: Byte lanes of a data access: size 0, 1, 2 cover 1, 2, 4 lanes starting at lane (offset-4), lanes past lane 3 dropped; write data is `acc_wdata` shifted left by 8*(offset-4).
- R6: A data read completes only after the downstream response; if claimed, `acc_rdata` is the response shifted right by 8*(offset-4) and masked to the access size.
- R7: A data read whose response is not claimed returns all ones masked to the access size.
- R8: While stored bit 31 is clear, a data access issues no request; a read returns all ones masked to its size and a write is dropped.
- R9: A 4-byte write at offset 0xE0 stores the status value and a read there returns it; narrower writes there are ignored.
- R10: `irq_out` is high in the cycle after any `slot_int` pin is high and low in the cycle after all are low.
- R11: Reads of any other offset return zero and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid | input | 1 | Register access request |
| acc_ready | output | 1 | Block can accept an access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| acc_wdata | input | 32 | Write value, right-aligned |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 32 | Read value, valid with acc_done |
| cfg_req_valid | output | 1 | One-cycle configuration request |
| cfg_req_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_func | output | 3 | Target function number |
| cfg_reg | output | 6 | Target dword register |
| cfg_be | output | 4 | Byte lanes of the request |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rsp_valid | input | 1 | Response pulse, at least one cycle after the request |
| cfg_rsp_claimed | input | 1 | A target accepted the request |
| cfg_rsp_rdata | input | 32 | Lane-aligned read data |
| slot_int | input | 4*NUM_SLOTS | Interrupt pins, four per slot |
| irq_out | output | 1 | Merged interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit offset and four slots, which gives sixteen interrupt pins. That small setting makes it cheap to sweep every offset and size combination on the address register. It also covers all twelve offset and size pairs of the data window for both directions, with claimed and unclaimed responses. It walks each interrupt pin on its own, so every lane shift, mask and merge input is hit at least once.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  // Byte lanes covered by an access of the given size code
  function automatic logic [3:0] size_lanes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_lanes = 4'b0001;
      2'd1:    size_lanes = 4'b0011;
      default: size_lanes = 4'b1111;
    endcase
  endfunction

  // Data mask of an access of the given size code
  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] addr_q,
  output logic              enabled,
  output logic [7:0]        f_bus,
  output logic [4:0]        f_dev,
  output logic [2:0]        f_func,
  output logic [5:0]        f_reg
);
  localparam int EN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (wr_en) begin
      addr_d         = wr_data;
      addr_d[1:0]    = 2'b00;
      addr_d[EN_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= addr_d;
  end

  assign enabled = addr_q[EN_BIT];
  assign f_bus   = addr_q[23:16];
  assign f_dev   = addr_q[15:11];
  assign f_func  = addr_q[10:8];
  assign f_reg   = addr_q[7:2];
endmodule

// File: rtl/cfgp_irq_merge.sv
module cfgp_irq_merge #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4*NUM_SLOTS-1:0] pins,
  output logic                   irq_q
);
  localparam int NPINS = 4 * NUM_SLOTS;

  logic [NPINS:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < NPINS; i++) begin : g_or
    assign chain[i+1] = chain[i] | pins[i];
  end

  logic irq_d;
  assign irq_d = chain[NPINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic        is_data,
  input  logic        acc_write,
  input  logic [1:0]  acc_off,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  input  logic [31:0] reg_rdata,
  input  logic        port_enabled,
  input  logic        rsp_valid,
  input  logic        rsp_claimed,
  input  logic [31:0] rsp_rdata,
  output logic        idle,
  output logic        done,
  output logic [31:0] rdata,
  output logic        req_valid,
  output logic        req_write,
  output logic [3:0]  req_be,
  output logic [31:0] req_wdata
);
  seq_state_t  state_q, state_d;
  logic [1:0]  off_q;
  logic [1:0]  size_q;
  logic        write_q;
  logic [31:0] wdata_q;
  logic [31:0] rdata_q, rdata_d;
  logic        ctx_en, rdata_en;
  logic [7:0]  lanes_wide;
  logic [63:0] wdata_wide;

  always_comb begin
    state_d  = state_q;
    rdata_d  = rdata_q;
    rdata_en = 1'b0;
    ctx_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fire) begin
          ctx_en   = 1'b1;
          rdata_en = 1'b1;
          if (is_data && port_enabled) begin
            state_d = ST_REQ;
            rdata_d = '0;
          end else begin
            state_d = ST_DONE;
            if (acc_write)    rdata_d = '0;
            else if (is_data) rdata_d = size_mask(acc_size);
            else              rdata_d = reg_rdata;
          end
        end
      end
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid) begin
          state_d  = ST_DONE;
          rdata_en = 1'b1;
          if (write_q)          rdata_d = '0;
          else if (rsp_claimed) rdata_d = (rsp_rdata >> {off_q, 3'b000}) & size_mask(size_q);
          else                  rdata_d = size_mask(size_q);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (ctx_en) begin
      off_q   <= acc_off;
      size_q  <= acc_size;
      write_q <= acc_write;
      wdata_q <= acc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign lanes_wide = {4'b0000, size_lanes(size_q)} << off_q;
  assign wdata_wide = {32'h0, wdata_q} << {off_q, 3'b000};

  assign idle      = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign rdata     = rdata_q;
  assign req_valid = (state_q == ST_REQ);
  assign req_write = write_q;
  assign req_be    = lanes_wide[3:0];
  assign req_wdata = wdata_wide[31:0];
endmodule

// File: rtl/cfg_addr_port.sv
module cfg_addr_port
  import cfgp_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          NUM_SLOTS  = 4,
  parameter logic [7:0]  STATUS_OFS = 8'hE0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  output logic                   acc_ready,
  input  logic                   acc_write,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [1:0]             acc_size,
  input  logic [31:0]            acc_wdata,
  output logic                   acc_done,
  output logic [31:0]            acc_rdata,
  output logic                   cfg_req_valid,
  output logic                   cfg_req_write,
  output logic [7:0]             cfg_bus,
  output logic [4:0]             cfg_dev,
  output logic [2:0]             cfg_func,
  output logic [5:0]             cfg_reg,
  output logic [3:0]             cfg_be,
  output logic [31:0]            cfg_wdata,
  input  logic                   cfg_rsp_valid,
  input  logic                   cfg_rsp_claimed,
  input  logic [31:0]            cfg_rsp_rdata,
  input  logic [4*NUM_SLOTS-1:0] slot_int,
  output logic                   irq_out
);
  localparam int                DATA_W   = 32;
  localparam logic [ADDR_W-1:0] OFS_ADDR = '0;
  localparam logic [ADDR_W-1:0] OFS_STS  = ADDR_W'(STATUS_OFS);
  localparam logic [1:0]        SZ_WORD  = 2'd2;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic        fire, is_data, is_addr, is_sts, full_wr;
  logic        addr_wr_en, sts_wr_en, seq_idle, port_en;
  logic [31:0] addr_q, status_q, reg_rdata;

  assign fire       = acc_valid & seq_idle;
  assign is_addr    = (acc_addr == OFS_ADDR);
  assign is_sts     = (acc_addr == OFS_STS);
  assign is_data    = (acc_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign full_wr    = fire & acc_write & (acc_size == SZ_WORD);
  assign addr_wr_en = full_wr & is_addr;
  assign sts_wr_en  = full_wr & is_sts;

  always_comb begin
    if (is_addr)     reg_rdata = addr_q;
    else if (is_sts) reg_rdata = status_q;
    else             reg_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    status_q <= '0;
    else if (sts_wr_en) status_q <= acc_wdata;
  end

  cfgp_addr_reg #(.DATA_W(DATA_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (addr_wr_en),
    .wr_data (acc_wdata),
    .addr_q  (addr_q),
    .enabled (port_en),
    .f_bus   (cfg_bus),
    .f_dev   (cfg_dev),
    .f_func  (cfg_func),
    .f_reg   (cfg_reg)
  );

  cfgp_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .fire         (fire),
    .is_data      (is_data),
    .acc_write    (acc_write),
    .acc_off      (acc_addr[1:0]),
    .acc_size     (acc_size),
    .acc_wdata    (acc_wdata),
    .reg_rdata    (reg_rdata),
    .port_enabled (port_en),
    .rsp_valid    (cfg_rsp_valid),
    .rsp_claimed  (cfg_rsp_claimed),
    .rsp_rdata    (cfg_rsp_rdata),
    .idle         (seq_idle),
    .done         (acc_done),
    .rdata        (acc_rdata),
    .req_valid    (cfg_req_valid),
    .req_write    (cfg_req_write),
    .req_be       (cfg_be),
    .req_wdata    (cfg_wdata)
  );

  cfgp_irq_merge #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pins  (slot_int),
    .irq_q (irq_out)
  );

  assign acc_ready = seq_idle;
endmodule

// File: rtl/cfg_addr_port_chk.sv
module cfg_addr_port_chk #(
  parameter int ADDR_W    = 8,
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic                   acc_ready,
  input logic                   acc_write,
  input logic [ADDR_W-1:0]      acc_addr,
  input logic [1:0]             acc_size,
  input logic [31:0]            acc_wdata,
  input logic                   cfg_req_valid,
  input logic [3:0]             cfg_be,
  input logic [31:0]            addr_q,
  input logic [31:0]            status_q,
  input logic [4*NUM_SLOTS-1:0] slot_int,
  input logic                   irq_out
);
  logic take;
  assign take = acc_valid && acc_ready;

  a_r2_short_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (take && acc_write && acc_addr == '0 && acc_size != 2'd2) |=> $stable(addr_q));

  a_r3_stored_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != 32'h0) |-> (addr_q[31] && addr_q[1:0] == 2'b00));

  a_r4_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> addr_q[31]);

  a_r4_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |=> !cfg_req_valid);

  a_r5_lanes_present: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_be != 4'b0000));

  a_r9_status_store: assert property (@(posedge clk) disable iff (!rst_n)
    (take && acc_write && acc_addr == ADDR_W'(8'hE0) && acc_size == 2'd2)
      |=> (status_q == $past(acc_wdata)));

  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_int != '0) |=> irq_out);

  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_int == '0) |=> !irq_out);
endmodule

bind cfg_addr_port cfg_addr_port_chk #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .acc_valid     (acc_valid),
  .acc_ready     (acc_ready),
  .acc_write     (acc_write),
  .acc_addr      (acc_addr),
  .acc_size      (acc_size),
  .acc_wdata     (acc_wdata),
  .cfg_req_valid (cfg_req_valid),
  .cfg_be        (cfg_be),
  .addr_q        (addr_q),
  .status_q      (status_q),
  .slot_int      (slot_int),
  .irq_out       (irq_out)
);

// File: tb/cfg_addr_port_test.sv
`timescale 1ns/1ps
module cfg_addr_port_test;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic        acc_ready, acc_done;
  logic [7:0]  acc_addr;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata, acc_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_rsp_valid, cfg_rsp_claimed;
  logic [31:0] cfg_rsp_rdata;
  logic [4*NS-1:0] slot_int;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  cfg_addr_port uut (.*);

  // results of the last access
  logic [31:0] r_data;
  int          r_reqs;
  logic        r_write;
  logic [7:0]  r_bus;
  logic [4:0]  r_dev;
  logic [2:0]  r_func;
  logic [5:0]  r_reg;
  logic [3:0]  r_be;
  logic [31:0] r_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic claim, input logic [31:0] rsp);
    r_reqs = 0;
    r_data = 'x;
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (cfg_req_valid) begin
        r_reqs++;
        r_write = cfg_req_write; r_bus = cfg_bus; r_dev = cfg_dev;
        r_func = cfg_func; r_reg = cfg_reg; r_be = cfg_be; r_wdata = cfg_wdata;
        @(negedge clk);
        if (cfg_req_valid) r_reqs++;
        @(negedge clk);
        cfg_rsp_valid = 1'b1; cfg_rsp_claimed = claim; cfg_rsp_rdata = rsp;
        @(negedge clk);
        cfg_rsp_valid = 1'b0;
      end
      if (acc_done) begin
        r_data = acc_rdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] fmask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] flanes(input int k, input logic [1:0] sz);
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    logic [3:0] m = '0;
    for (int b = 0; b < 4; b++) if (b >= k && b < k + n) m[b] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] stored;
    logic [31:0] v;
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_size = '0;
    acc_wdata = '0; cfg_rsp_valid = 1'b0; cfg_rsp_claimed = 1'b0; cfg_rsp_rdata = '0;
    slot_int = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    check("R1 req", {31'b0, cfg_req_valid}, 32'h0);
    access(1'b0, 8'h00, 2'd2, 0, 1'b0, 0);
    check("R1 addr", r_data, 32'h0);
    access(1'b0, 8'hE0, 2'd2, 0, 1'b0, 0);
    check("R1 status", r_data, 32'h0);

    // R8 port disabled: no request, reads all ones masked
    for (int s = 0; s < 3; s++) begin
      access(1'b0, 8'h04 + 8'(s), 2'(s), 0, 1'b1, 32'h1234_5678);
      check("R8 rd reqs", 32'(r_reqs), 0);
      check("R8 rd data", r_data, fmask(2'(s)));
    end
    access(1'b1, 8'h04, 2'd2, 32'hDEAD_BEEF, 1'b1, 0);
    check("R8 wr reqs", 32'(r_reqs), 0);

    // R2 / R3 address write sweep over offset and size
    stored = 32'h0;
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 3; s++) begin
        v = 32'h0123_4567 ^ (32'(o) << 12) ^ (32'(s) << 20) | 32'h3;
        access(1'b1, 8'(o), 2'(s), v, 1'b0, 0);
        if (o == 0 && s == 2) stored = (v & 32'hFFFF_FFFC) | 32'h8000_0000;
        access(1'b0, 8'h00, 2'd2, 0, 1'b0, 0);
        check((o == 0 && s == 2) ? "R3 cleaned store" : "R2 ignored write", r_data, stored);
      end

    // R4 decode of fields, several addresses
    for (int t = 0; t < 6; t++) begin
      v = (32'(t * 37 + 5) << 16) | (32'((t * 7 + 3) & 31) << 11) |
          (32'(t & 7) << 8) | (32'((t * 11 + 1) & 63) << 2);
      access(1'b1, 8'h00, 2'd2, v, 1'b0, 0);
      access(1'b0, 8'h04, 2'd2, 0, 1'b1, 32'hA5A5_5A5A);
      check("R4 one req", 32'(r_reqs), 1);
      check("R4 bus",  32'(r_bus),  32'(v[23:16]));
      check("R4 dev",  32'(r_dev),  32'(v[15:11]));
      check("R4 func", 32'(r_func), 32'(v[10:8]));
      check("R4 reg",  32'(r_reg),  32'(v[7:2]));
    end

    // R5 / R6 / R7 data window sweep
    access(1'b1, 8'h00, 2'd0 + 2'd2, 32'h0005_1A2C, 1'b0, 0);
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 3; s++) begin
        v = 32'hC3B2_A190 + 32'(k * 16 + s);
        access(1'b1, 8'h04 + 8'(k), 2'(s), v, 1'b1, 0);
        check("R5 write dir", {31'b0, r_write}, 32'h1);
        check("R5 write lanes", 32'(r_be), 32'(flanes(k, 2'(s))));
        check("R5 write data", r_wdata, v << (8 * k));
        access(1'b0, 8'h04 + 8'(k), 2'(s), 0, 1'b1, v);
        check("R5 read lanes", 32'(r_be), 32'(flanes(k, 2'(s))));
        check("R6 claimed read", r_data, (v >> (8 * k)) & fmask(2'(s)));
        access(1'b0, 8'h04 + 8'(k), 2'(s), 0, 1'b0, v);
        check("R7 unclaimed read", r_data, fmask(2'(s)));
      end

    // R9 status register
    access(1'b1, 8'hE0, 2'd2, 32'h5EED_F00D, 1'b0, 0);
    access(1'b0, 8'hE0, 2'd2, 0, 1'b0, 0);
    check("R9 status full", r_data, 32'h5EED_F00D);
    for (int s = 0; s < 2; s++) begin
      access(1'b1, 8'hE0, 2'(s), 32'h0000_0011, 1'b0, 0);
      access(1'b0, 8'hE0, 2'd2, 0, 1'b0, 0);
      check("R9 status narrow ignored", r_data, 32'h5EED_F00D);
    end

    // R11 other offsets
    access(1'b0, 8'h40, 2'd2, 0, 1'b0, 0);
    check("R11 read zero", r_data, 0);
    access(1'b0, 8'h02, 2'd2, 0, 1'b0, 0);
    check("R11 read off2 zero", r_data, 0);
    access(1'b1, 8'h40, 2'd2, 32'hFFFF_FFFF, 1'b0, 0);
    check("R11 write no req", 32'(r_reqs), 0);
    access(1'b0, 8'hE0, 2'd2, 0, 1'b0, 0);
    check("R11 status kept", r_data, 32'h5EED_F00D);
    access(1'b0, 8'h00, 2'd2, 0, 1'b0, 0);
    check("R11 addr kept", r_data, 32'h8005_1A2C);

    // R10 interrupt merge, walk each pin
    for (int p = 0; p < 4 * NS; p++) begin
      @(negedge clk); slot_int = '0; slot_int[p] = 1'b1;
      @(negedge clk);
      check("R10 irq high", {31'b0, irq_out}, 32'h1);
      slot_int = '0;
      @(negedge clk);
      check("R10 irq low", {31'b0, irq_out}, 32'h0);
    end
    @(negedge clk); slot_int = '1;
    @(negedge clk);
    check("R10 irq all", {31'b0, irq_out}, 32'h1);
    slot_int = '0;

    // R1 reset again clears registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 8'h00, 2'd2, 0, 1'b0, 0);
    check("R1 addr after reset", r_data, 0);
    access(1'b0, 8'hE0, 2'd2, 0, 1'b0, 0);
    check("R1 status after reset", r_data, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule